// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of a memory read or write burst. When a start strobe arrives with a starting column, a burst-length code and an ordering bit, it emits one column address per clock for the programmed number of beats. A valid flag marks each beat, and a last-beat flag marks the final beat of a fixed-length burst.

Fixed lengths of 2, 4 and 8 wrap inside the aligned block of that size. The beats inside that block step in either linear order or exclusive-or order. A full-page setting walks the whole 256-column row with wrap-around and never ends by itself: only a terminate input or a new start stops it.

A new start may arrive on any cycle, including in the middle of a burst, so the column can change on every clock. When the self-timed precharge option is captured with the start, the block raises a one-cycle precharge request right after the final beat of a fixed-length burst.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `valid_o`, `last_o` and `pre_o` are 0 and `col_o` is 0.
- R2: When `start_i` is sampled high, `valid_o` is 1 in the next cycle with `col_o` equal to the sampled `start_col_i`. Beat k of the burst appears k cycles after beat 0, with one beat per cycle.
- R3: Length code `len_code_i` is 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8 and 7 for full page, and codes 4 to 6 act as 1 beat. A fixed-length burst raises `last_o` together with its final beat, and `valid_o` is 0 in the cycle after that beat unless a new start was sampled.
- R4: With `interleave_i` = 0 and length L in {2,4,8}, beat k has the start column's bits above log2(L) unchanged and low bits equal to (start + k) mod L.
- R5: With `interleave_i` = 1 and length L in {2,4,8}, beat k has the upper bits unchanged and low bits equal to (start XOR k) mod L.
- R6: In full-page mode beat k is (start + k) mod 256 whatever `interleave_i` is. `last_o` stays 0, and the burst continues past 256 beats until it is stopped.
- R7: `term_i` sampled high during a beat, with no start in the same cycle, makes `valid_o` 0 in the next cycle. `term_i` has no effect while idle, and a start in the same cycle takes priority over it.
- R8: A start sampled during a burst abandons that burst, and the new burst's beat 0 appears in the next cycle.
- R9: If `auto_pre_i` was 1 at the start, `pre_o` is 1 for exactly the one cycle after the cycle that showed the final beat of a fixed-length burst, whether or not `term_i` was also high then. Otherwise, and after a burst cut short before its final beat, `pre_o` stays 0.
- R10: Whenever `valid_o` is 0, `last_o` is 0 and `col_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Accept a READ/WRITE command and begin a burst |
| start_col_i | input | 8 | Starting column captured with the start |
| len_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 1 = exclusive-or beat order, 0 = linear |
| auto_pre_i | input | 1 | Request precharge at the end of this burst |
| term_i | input | 1 | Burst terminate |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The current beat is the final one |
| pre_o | output | 1 | One-cycle self-timed precharge request |

## Verification
The bench aims at start columns that are not aligned to the block size. A generator that carried into the upper bits instead of wrapping inside the block would produce columns from the neighbouring block. It runs full-page bursts beyond 256 beats, where a generator that treated full page as a fixed length would raise a last beat or stop at the row end. Terminate is tried on the final beat, in mid-burst, while idle and together with a start, so a wrong priority shows up as a missing or extra beat or a spurious precharge pulse. A restart in mid-burst checks that the old burst leaves no precharge request behind and that the new beat 0 follows at once.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  // width of the burst-length code
  localparam int unsigned LEN_CODE_W = 3;
  // largest fixed length is 2**LEN_LOG_MAX beats
  localparam int unsigned LEN_LOG_MAX = 3;
  // code that selects a whole-row burst
  localparam logic [LEN_CODE_W-1:0] LEN_CODE_FULL = 3'd7;

  // per-burst options captured with the start strobe
  typedef struct packed {
    logic full;
    logic ilv;
    logic ap;
  } burst_opt_t;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o
);
  logic code_ok;

  assign full_o  = (len_code_i == LEN_CODE_FULL);
  assign code_ok = (int'(len_code_i) <= int'(LEN_LOG_MAX));

  // bit i of the wrap mask is set when the block size exceeds 2**i
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o | (code_ok & (int'(len_code_i) > i));
  end
endmodule

// File: rtl/colgen_addr_step.sv
module colgen_addr_step #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] lin_sum;
  logic [COL_W-1:0] xor_mix;
  logic [COL_W-1:0] low_pick;

  assign lin_sum  = base_i + beat_i;
  assign xor_mix  = base_i ^ beat_i;
  // whole-row bursts always step linearly
  assign low_pick = (ilv_i & ~full_i) ? xor_mix : lin_sum;

  // bits inside the wrap block move, bits above it stay put
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign addr_o[i] = mask_i[i] ? low_pick[i] : base_i[i];
  end
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  interleave_i,
  input  logic                  auto_pre_i,
  input  logic                  term_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o,
  output logic                  pre_o
);
  // captured burst context
  logic [COL_W-1:0] base_q, mask_q, beat_q;
  burst_opt_t       opt_q;

  // next-cycle context
  logic [COL_W-1:0] base_n, mask_n, beat_n, addr_n;
  burst_opt_t       opt_n;
  logic             go_n, last_n, end_now;

  logic [COL_W-1:0] mask_in;
  logic             full_in;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code_i (len_code_i),
    .mask_o     (mask_in),
    .full_o     (full_in)
  );

  always_comb begin
    end_now = valid_o & (last_o | term_i);
    if (start_i) begin
      go_n      = 1'b1;
      beat_n    = '0;
      base_n    = start_col_i;
      mask_n    = mask_in;
      opt_n.full = full_in;
      opt_n.ilv  = interleave_i;
      opt_n.ap   = auto_pre_i;
    end else begin
      go_n   = valid_o & ~end_now;
      beat_n = beat_q + 1'b1;
      base_n = base_q;
      mask_n = mask_q;
      opt_n  = opt_q;
    end
    last_n = go_n & ~opt_n.full & (beat_n == mask_n);
  end

  colgen_addr_step #(.COL_W(COL_W)) u_step (
    .base_i (base_n),
    .beat_i (beat_n),
    .mask_i (mask_n),
    .full_i (opt_n.full),
    .ilv_i  (opt_n.ilv),
    .addr_o (addr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      pre_o   <= 1'b0;
      beat_q  <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      opt_q   <= '0;
    end else begin
      valid_o <= go_n;
      col_o   <= go_n ? addr_n : '0;
      last_o  <= last_n;
      pre_o   <= valid_o & last_o & opt_q.ap;
      beat_q  <= go_n ? beat_n : '0;
      base_q  <= base_n;
      mask_q  <= mask_n;
      opt_q   <= opt_n;
    end
  end
endmodule

// File: rtl/sdram_col_burst_gen_chk.sv
module sdram_col_burst_gen_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             pre_o
);
  p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  p_single_last_r3: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_code_i == 3'd0) |=> last_o);

  p_end_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && !start_i) |=> !valid_o);

  p_term_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && term_i && !start_i) |=> !valid_o);

  p_pre_source_r9: assert property (@(posedge clk) disable iff (rst)
    pre_o |-> $past(valid_o && last_o));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (!last_o && col_o == '0));
endmodule

bind sdram_col_burst_gen sdram_col_burst_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .pre_o       (pre_o)
);

// File: tb/tb_sdram_col_burst_gen.sv
module tb_sdram_col_burst_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       auto_pre_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, pre_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_col_burst_gen dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i),
    .auto_pre_i(auto_pre_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .pre_o(pre_o)
  );

  function automatic int len_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int s, int code, int ilv, int k);
    int l, m, lo;
    if (code == 7) return (s + k) % 256;
    l  = len_of(code);
    m  = l - 1;
    lo = ilv ? ((s ^ k) & m) : ((s + k) & m);
    return (s & (255 - m)) | lo;
  endfunction

  task automatic check(int act, int exp, string tag);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // term_k < 0: no terminate; otherwise terminate during beat term_k
  task automatic burst(int s, int code, int ilv, int ap, int term_k);
    int l, full, k, ended_last;
    l = len_of(code);
    full = (code == 7);
    ended_last = 0;
    @(negedge clk);
    start_i = 1; start_col_i = 8'(s); len_code_i = 3'(code);
    interleave_i = 1'(ilv); auto_pre_i = 1'(ap);
    @(negedge clk);
    start_i = 0;
    k = 0;
    forever begin
      check(valid_o, 1, "R2 valid during beat");
      if (code == 7) check(col_o, exp_col(s, code, ilv, k), "R6 full-page column");
      else if (ilv != 0 && l > 1) check(col_o, exp_col(s, code, ilv, k), "R5 interleaved column");
      else check(col_o, exp_col(s, code, ilv, k), "R4 sequential column");
      if (full) check(last_o, 0, "R6 no last in full page");
      else check(last_o, (k == l - 1) ? 1 : 0, "R3 last flag");
      if (!full && k == l - 1) ended_last = 1;
      if (k == term_k) begin
        term_i = 1;
        @(negedge clk);
        term_i = 0;
        break;
      end
      @(negedge clk);
      if (ended_last) break;
      k++;
    end
    check(valid_o, 0, (term_k >= 0) ? "R7 stop after terminate" : "R3 stop after last");
    check(col_o, 0, "R10 idle column");
    check(last_o, 0, "R10 idle last");
    check(pre_o, (ap != 0 && ended_last) ? 1 : 0, "R9 precharge request");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int codes[8] = '{0, 1, 2, 3, 7, 4, 5, 6};
    void'($urandom(32'h5D1A_7C03));
    repeat (3) @(negedge clk);
    check(valid_o, 0, "R1 valid in reset");
    check(pre_o, 0, "R1 pre in reset");
    rst = 0;
    @(negedge clk);
    check(valid_o, 0, "R1 valid after reset");
    check(last_o, 0, "R1 last after reset");
    check(pre_o, 0, "R1 pre after reset");
    check(col_o, 0, "R1 column after reset");

    // directed corners
    burst(8'h35, 3, 0, 1, -1);   // unaligned 8-beat sequential wrap
    burst(8'h35, 3, 1, 0, -1);   // 8-beat interleaved
    burst(8'h0E, 2, 1, 1, -1);
    burst(8'hFF, 1, 0, 1, -1);
    burst(8'h42, 0, 0, 1, -1);   // single beat
    burst(8'h42, 5, 0, 1, -1);   // reserved code acts as one beat
    burst(8'hFA, 7, 1, 1, 270);  // full page past the row end, interleave ignored
    burst(8'h13, 3, 0, 1, 7);    // terminate on last beat: precharge still fires
    burst(8'h13, 3, 0, 1, 2);    // terminate early: no precharge

    // terminate while idle: R7
    @(negedge clk);
    term_i = 1;
    @(negedge clk);
    term_i = 0;
    check(valid_o, 0, "R7 terminate while idle");
    check(col_o, 0, "R7 idle column unchanged");

    // start together with terminate: start wins (R7)
    start_i = 1; term_i = 1; start_col_i = 8'h21; len_code_i = 3'd1;
    interleave_i = 0; auto_pre_i = 0;
    @(negedge clk);
    start_i = 0; term_i = 0;
    check(valid_o, 1, "R7 start beats terminate");
    check(col_o, 8'h21, "R7 start beats terminate column");
    @(negedge clk);
    check(col_o, 8'h20, "R4 second beat wraps");
    @(negedge clk);

    // restart mid-burst: R8
    start_i = 1; start_col_i = 8'h80; len_code_i = 3'd3; auto_pre_i = 1;
    @(negedge clk);
    start_i = 0;
    @(negedge clk);
    @(negedge clk);
    check(col_o, 8'h82, "R8 old burst beat 2");
    start_i = 1; start_col_i = 8'h5C; len_code_i = 3'd2; interleave_i = 1; auto_pre_i = 0;
    @(negedge clk);
    start_i = 0;
    check(valid_o, 1, "R8 restart valid");
    check(col_o, 8'h5C, "R8 restart beat 0");
    check(pre_o, 0, "R8 no precharge from abandoned burst");
    @(negedge clk);
    check(col_o, 8'h5D, "R8 restart beat 1");
    @(negedge clk);
    check(col_o, 8'h5E, "R8 restart beat 2");
    @(negedge clk);
    check(col_o, 8'h5F, "R8 restart beat 3");
    check(last_o, 1, "R8 restart last");
    @(negedge clk);
    check(valid_o, 0, "R8 restart ends");
    check(pre_o, 0, "R9 no precharge when option off");

    // constrained random bursts
    for (int n = 0; n < 250; n++) begin
      int s, code, ilv, ap, tk, l;
      s    = int'($urandom_range(0, 255));
      code = codes[$urandom_range(0, 7)];
      ilv  = int'($urandom_range(0, 1));
      ap   = int'($urandom_range(0, 1));
      l    = len_of(code);
      if (code == 7) tk = int'($urandom_range(0, 40));
      else if ($urandom_range(0, 3) == 0) tk = int'($urandom_range(0, l - 1));
      else tk = -1;
      burst(s, code, ilv, ap, tk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule